// File: doc/BRIEF.md
# Program Trace Capture Unit

The block records program-counter values into a small circular trace memory. Each cycle the core reports one retired execution set: its PC, whether it carried a mark instruction, whether a change of flow was taken (with its target), whether a hardware loop closed (with its start address and a long/short flag), and whether an interrupt or exception was entered (with the interrupted PC and the vector PC). A control register chooses which of these occurrences are logged. Capture runs only while the external `trace_active` input is high.

Software reads the log through four registers on a simple strobe bus. Address 0 holds the control register, address 1 the read pointer, address 2 the write pointer, and address 3 is a virtual data register. Each read of address 3 returns the oldest entry and removes it from the log. The log holds 16 entries. When it is full, new entries replace the oldest ones. Reads have no wait states: `reg_rdata` is combinational for the address presented, and any side effect of a strobe takes place at the next rising clock edge.

Some conventions for the inputs:
- For a loop event, the PC of the loop-closing set (`es_pc`) is taken as the loop's last address.
- Trap and illegal-instruction entries arrive on the interrupt inputs.
- Break and continue arrive as taken changes of flow.

Top module: `trace_capture`

## Requirements
- R1: After reset, the control register, both pointers and the data register all read zero.
- R2: Control bit 0 selects the every-set mode. In this mode, each captured set writes exactly one entry, `es_pc`, whatever other status flags it carries.
- R3: Control bit 1 selects the mark mode. In this mode, only sets with `es_mark` high write one entry, `es_pc`.
- R4: Control bit 2 selects the change-of-flow mode. A set with `es_cof_taken` high writes two entries: first `es_pc`, then `es_cof_dst`.
- R5: Control bit 3 selects the loop mode. On `es_loop_end`, a long loop (`es_loop_long` high) writes `es_pc` and then `es_loop_sa`. A short loop writes only `es_pc`.
- R6: Control bit 4 selects the interrupt mode. On `es_int`, the block writes `es_int_pc` and then `es_int_vec`.
- R7: When several enabled events share one set, only the highest-priority event is logged, so at most two entries are written per cycle. The order from highest priority is interrupt, then change of flow, then loop.
- R8: A write to control is illegal if it sets bit 0 or bit 1 together with any other bit of [4:0].
  - An illegal write leaves the mode unchanged and sets the error flag (control bit 8).
  - A legal write loads bits [4:0], clears the error flag, and clears the overflow flag (control bit 9).
- R9: No entry is written in a cycle where `trace_active` or `es_valid` is low.
- R10: The log holds 16 entries and wraps around. Each entry written while the log is full replaces the oldest entry, advances the read pointer by one, and sets the sticky overflow flag.
- R11: A read of address 3 returns the entry at the read pointer and then advances the read pointer. Addresses 1 and 2 return the pointers modulo 16.
- R12: A read of address 3 while the log is empty returns zero and leaves the read pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_active | input | 1 | Capture enable from the debug logic |
| es_valid | input | 1 | An execution set retires this cycle |
| es_pc | input | PC_W | PC of the retiring set |
| es_mark | input | 1 | Set holds a mark instruction |
| es_cof_taken | input | 1 | Set takes a change of flow |
| es_cof_dst | input | PC_W | Change-of-flow target |
| es_loop_end | input | 1 | Set closes a hardware loop iteration |
| es_loop_long | input | 1 | The closing loop is a long loop |
| es_loop_sa | input | PC_W | Loop start address |
| es_int | input | 1 | Interrupt or exception entry |
| es_int_pc | input | PC_W | Interrupted PC |
| es_int_vec | input | PC_W | Handler vector PC |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | PC_W | Write data |
| reg_rdata | output | PC_W | Read data for `reg_addr` |

## Verification
The flag and pointer properties assume that every bus strobe and address is a known value once reset is released. They also assume that a stalled log can only be seen in cycles where `trace_active` is low, since that is the only way they can tell a capture from a pop. The stimulus changes inputs only between clock edges and issues at most one register access per cycle. Pops are never placed in the same cycle as a capture, so the order in which the bench's model applies a pop and a write is never in doubt. The mode sweep keeps `trace_active` high and runs every enabled-mode subset against every event combination, so the priority rule is exercised in full.

// File: rtl/trc_pkg.sv
`timescale 1ns/1ps
package trc_pkg;

  localparam int MODE_W  = 5;
  localparam int ERR_BIT = 8;
  localparam int OVF_BIT = 9;

  // bit 0 every-set, bit 1 mark, bit 2 change of flow, bit 3 loop, bit 4 interrupt
  typedef struct packed {
    logic intr;
    logic loop;
    logic cof;
    logic mark;
    logic every;
  } trc_mode_t;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_RPTR = 2'd1,
    REG_WPTR = 2'd2,
    REG_DATA = 2'd3
  } trc_reg_e;

  // every-set and mark must each stand alone
  function automatic logic mode_legal(input trc_mode_t m);
    logic [MODE_W-1:0] bits;
    bits = m;
    if (m.every || m.mark) return ($countones(bits) == 1);
    return 1'b1;
  endfunction

endpackage

// File: rtl/trc_ctrl.sv
`timescale 1ns/1ps
module trc_ctrl
  import trc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  trc_mode_t wr_mode,
  output trc_mode_t mode,
  output logic      err,
  output logic      accept
);

  trc_mode_t mode_n;
  logic      err_n;
  logic      legal;

  always_comb begin
    legal  = mode_legal(wr_mode);
    accept = wr_en && legal;
    mode_n = mode;
    err_n  = err;
    if (wr_en) begin
      if (legal) begin
        mode_n = wr_mode;
        err_n  = 1'b0;
      end else begin
        err_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      err  <= 1'b0;
    end else begin
      mode <= mode_n;
      err  <= err_n;
    end
  end

endmodule

// File: rtl/trc_select.sv
`timescale 1ns/1ps
module trc_select
  import trc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  trc_mode_t        mode,
  input  logic             active,
  input  logic             valid,
  input  logic [PC_W-1:0]  pc,
  input  logic             mark,
  input  logic             cof_taken,
  input  logic [PC_W-1:0]  cof_dst,
  input  logic             loop_end,
  input  logic             loop_long,
  input  logic [PC_W-1:0]  loop_sa,
  input  logic             intr,
  input  logic [PC_W-1:0]  int_pc,
  input  logic [PC_W-1:0]  int_vec,
  output logic [1:0]       n_ent,
  output logic [PC_W-1:0]  ent0,
  output logic [PC_W-1:0]  ent1
);

  logic fire;
  logic hit_int, hit_cof, hit_loop;

  always_comb begin
    fire     = active && valid;
    hit_int  = mode.intr && intr;
    hit_cof  = mode.cof  && cof_taken;
    hit_loop = mode.loop && loop_end;
    n_ent    = 2'd0;
    ent0     = '0;
    ent1     = '0;
    if (fire) begin
      if (mode.every) begin
        n_ent = 2'd1;
        ent0  = pc;
      end else if (mode.mark) begin
        if (mark) begin
          n_ent = 2'd1;
          ent0  = pc;
        end
      end else if (hit_int) begin
        n_ent = 2'd2;
        ent0  = int_pc;
        ent1  = int_vec;
      end else if (hit_cof) begin
        n_ent = 2'd2;
        ent0  = pc;
        ent1  = cof_dst;
      end else if (hit_loop) begin
        n_ent = loop_long ? 2'd2 : 2'd1;
        ent0  = pc;
        ent1  = loop_sa;
      end
    end
  end

endmodule

// File: rtl/trc_buf.sv
`timescale 1ns/1ps
module trc_buf #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 push_n,
  input  logic [PC_W-1:0]            ent0,
  input  logic [PC_W-1:0]            ent1,
  input  logic                       pop_req,
  input  logic                       ovf_clr,
  output logic [PC_W-1:0]            rd_data,
  output logic [$clog2(DEPTH)-1:0]   rptr,
  output logic [$clog2(DEPTH)-1:0]   wptr,
  output logic [$clog2(DEPTH):0]     cnt,
  output logic                       ovf
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W:0] DEPTH_X = (CNT_W+1)'(DEPTH);

  logic [PC_W-1:0]  slot [DEPTH];
  logic [DEPTH-1:0] we0, we1;
  logic [PTR_W-1:0] wptr1;

  logic             pop;
  logic [CNT_W:0]   after_pop, total, drop;
  logic [CNT_W-1:0] cnt_n;
  logic [PTR_W-1:0] rptr_n, wptr_n;
  logic             ovf_n;

  assign wptr1 = wptr + 1'b1;

  // per-slot write decode: first entry at wptr, second at wptr+1
  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign we0[g] = (push_n != 2'd0) && (wptr  == PTR_W'(g));
    assign we1[g] = (push_n == 2'd2) && (wptr1 == PTR_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we0[i])      slot[i] <= ent0;
      else if (we1[i]) slot[i] <= ent1;
    end
  end

  always_comb begin
    pop       = pop_req && (cnt != '0);
    after_pop = {1'b0, cnt} - (CNT_W+1)'(pop);
    total     = after_pop + (CNT_W+1)'(push_n);
    drop      = (total > DEPTH_X) ? (total - DEPTH_X) : '0;
    cnt_n     = CNT_W'(total - drop);
    rptr_n    = rptr + PTR_W'(pop) + PTR_W'(drop);
    wptr_n    = wptr + PTR_W'(push_n);
    if (drop != '0)  ovf_n = 1'b1;
    else if (ovf_clr) ovf_n = 1'b0;
    else              ovf_n = ovf;
    rd_data   = (cnt != '0) ? slot[rptr] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
      wptr <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
    end else begin
      rptr <= rptr_n;
      wptr <= wptr_n;
      cnt  <= cnt_n;
      ovf  <= ovf_n;
    end
  end

endmodule

// File: rtl/trace_capture.sv
`timescale 1ns/1ps
module trace_capture
  import trc_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trace_active,
  input  logic            es_valid,
  input  logic [PC_W-1:0] es_pc,
  input  logic            es_mark,
  input  logic            es_cof_taken,
  input  logic [PC_W-1:0] es_cof_dst,
  input  logic            es_loop_end,
  input  logic            es_loop_long,
  input  logic [PC_W-1:0] es_loop_sa,
  input  logic            es_int,
  input  logic [PC_W-1:0] es_int_pc,
  input  logic [PC_W-1:0] es_int_vec,
  input  logic            reg_wr_en,
  input  logic            reg_rd_en,
  input  logic [1:0]      reg_addr,
  input  logic [PC_W-1:0] reg_wdata,
  output logic [PC_W-1:0] reg_rdata
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  trc_mode_t        ctl_mode;
  logic             ctl_err;
  logic             ctl_accept;
  logic             ctl_wr;
  logic             data_pop;
  logic [1:0]       sel_n;
  logic [PC_W-1:0]  sel_e0, sel_e1;
  logic [PC_W-1:0]  buf_data;
  logic [PTR_W-1:0] buf_rptr, buf_wptr;
  logic [CNT_W-1:0] buf_cnt;
  logic             buf_ovf;
  logic             unused_wdata;

  assign ctl_wr       = reg_wr_en && (reg_addr == REG_CTRL);
  assign data_pop     = reg_rd_en && (reg_addr == REG_DATA);
  assign unused_wdata = ^reg_wdata[PC_W-1:MODE_W];

  trc_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_wr),
    .wr_mode (trc_mode_t'(reg_wdata[MODE_W-1:0])),
    .mode    (ctl_mode),
    .err     (ctl_err),
    .accept  (ctl_accept)
  );

  trc_select #(.PC_W(PC_W)) u_sel (
    .mode      (ctl_mode),
    .active    (trace_active),
    .valid     (es_valid),
    .pc        (es_pc),
    .mark      (es_mark),
    .cof_taken (es_cof_taken),
    .cof_dst   (es_cof_dst),
    .loop_end  (es_loop_end),
    .loop_long (es_loop_long),
    .loop_sa   (es_loop_sa),
    .intr      (es_int),
    .int_pc    (es_int_pc),
    .int_vec   (es_int_vec),
    .n_ent     (sel_n),
    .ent0      (sel_e0),
    .ent1      (sel_e1)
  );

  trc_buf #(.PC_W(PC_W), .DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_n  (sel_n),
    .ent0    (sel_e0),
    .ent1    (sel_e1),
    .pop_req (data_pop),
    .ovf_clr (ctl_accept),
    .rd_data (buf_data),
    .rptr    (buf_rptr),
    .wptr    (buf_wptr),
    .cnt     (buf_cnt),
    .ovf     (buf_ovf)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      REG_CTRL: begin
        reg_rdata[MODE_W-1:0] = ctl_mode;
        reg_rdata[ERR_BIT]    = ctl_err;
        reg_rdata[OVF_BIT]    = buf_ovf;
      end
      REG_RPTR: reg_rdata[PTR_W-1:0] = buf_rptr;
      REG_WPTR: reg_rdata[PTR_W-1:0] = buf_wptr;
      default:  reg_rdata = buf_data;
    endcase
  end

endmodule

// File: rtl/trc_capture_chk.sv
`timescale 1ns/1ps
module trc_capture_chk #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     trace_active,
  input logic                     reg_wr_en,
  input logic                     reg_rd_en,
  input logic [1:0]               reg_addr,
  input logic [4:0]               wr_mode,
  input logic [PC_W-1:0]          reg_rdata,
  input logic [$clog2(DEPTH):0]   cnt,
  input logic [$clog2(DEPTH)-1:0] rptr,
  input logic [$clog2(DEPTH)-1:0] wptr,
  input logic [4:0]               mode,
  input logic                     err,
  input logic                     ovf
);

  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic wr_ctrl, bad_wr, good_wr, pop;

  assign wr_ctrl = reg_wr_en && (reg_addr == 2'd0);
  assign bad_wr  = wr_ctrl && (wr_mode[1:0] != 2'b00) && ($countones(wr_mode) > 1);
  assign good_wr = wr_ctrl && !bad_wr;
  assign pop     = reg_rd_en && (reg_addr == 2'd3);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH)); // R10

  AST_RPTR_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && cnt < CNT_W'(DEPTH-1)) |=> $stable(rptr)); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !good_wr) |=> ovf); // R10

  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] || mode[1]) |-> ($countones(mode) == 1)); // R8

  AST_BAD_WR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> err); // R8

  AST_BAD_WR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> $stable(mode)); // R8

  AST_IDLE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!trace_active && !pop) |=> ($stable(wptr) && $stable(cnt))); // R9

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt == '0) |-> (reg_rdata == '0)); // R12

  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt == '0 && !trace_active) |=> $stable(rptr)); // R12

endmodule

bind trace_capture trc_capture_chk #(.PC_W(PC_W), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .trace_active (trace_active),
  .reg_wr_en    (reg_wr_en),
  .reg_rd_en    (reg_rd_en),
  .reg_addr     (reg_addr),
  .wr_mode      (reg_wdata[4:0]),
  .reg_rdata    (reg_rdata),
  .cnt          (buf_cnt),
  .rptr         (buf_rptr),
  .wptr         (buf_wptr),
  .mode         (ctl_mode),
  .err          (ctl_err),
  .ovf          (buf_ovf)
);

// File: tb/trace_capture_test.sv
`timescale 1ns/1ps
module trace_capture_test;

  localparam int PC_W  = 32;
  localparam int DEPTH = 16;

  logic            clk, rst_n, trace_active, es_valid, es_mark, es_cof_taken;
  logic            es_loop_end, es_loop_long, es_int, reg_wr_en, reg_rd_en;
  logic [PC_W-1:0] es_pc, es_cof_dst, es_loop_sa, es_int_pc, es_int_vec;
  logic [PC_W-1:0] reg_wdata, reg_rdata;
  logic [1:0]      reg_addr;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // bench model of the log, ctrl mode and flags
  int m_mem [DEPTH];
  int m_r, m_w, m_cnt, m_mode;
  bit m_ovf, m_err;

  trace_capture #(.PC_W(PC_W), .DEPTH(DEPTH)) uut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    es_valid = 0; es_pc = '0; es_mark = 0; es_cof_taken = 0; es_cof_dst = '0;
    es_loop_end = 0; es_loop_long = 0; es_loop_sa = '0; es_int = 0;
    es_int_pc = '0; es_int_vec = '0; reg_wr_en = 0; reg_rd_en = 0;
    reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); clear_in();
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); clear_in();
    reg_rd_en = 1; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic es_step(input logic act, input logic v, input logic [31:0] pc,
                         input logic mk, input logic cof, input logic [31:0] dst,
                         input logic le, input logic lg, input logic [31:0] sa,
                         input logic it, input logic [31:0] ipc, input logic [31:0] ivec);
    @(negedge clk); clear_in();
    trace_active = act; es_valid = v; es_pc = pc; es_mark = mk;
    es_cof_taken = cof; es_cof_dst = dst; es_loop_end = le; es_loop_long = lg;
    es_loop_sa = sa; es_int = it; es_int_pc = ipc; es_int_vec = ivec;
  endtask

  function automatic void m_push(input int v);
    m_mem[m_w] = v;
    m_w = (m_w + 1) % DEPTH;
    if (m_cnt == DEPTH) begin
      m_r   = (m_r + 1) % DEPTH;
      m_ovf = 1;
    end else begin
      m_cnt++;
    end
  endfunction

  function automatic void m_ctrl(input int m);
    if (((m & 3) == 0) || m == 1 || m == 2) begin
      m_mode = m; m_err = 0; m_ovf = 0;
    end else begin
      m_err = 1;
    end
  endfunction

  task automatic drain(input string req);
    logic [31:0] d;
    while (m_cnt > 0) begin
      reg_read(2'd3, d);
      chk(req, d, m_mem[m_r]);
      m_r = (m_r + 1) % DEPTH;
      m_cnt--;
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, r0;
    m_r = 0; m_w = 0; m_cnt = 0; m_mode = 0; m_ovf = 0; m_err = 0;
    rst_n = 0; trace_active = 0; clear_in();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), d);
      chk("R1", d, 0);
    end

    // R2 / R9: every-set mode with gaps in valid and trace_active
    reg_write(2'd0, 32'd1); m_ctrl(1);
    for (int i = 0; i < 12; i++) begin
      logic v, a;
      v = (i % 4) != 3;
      a = (i % 5) != 4;
      es_step(a, v, 32'h1000 + 32'(i*4), i[0], i[1], 32'hDEAD0000, i[2], 1'b1,
              32'h5, i[3], 32'h7, 32'h9);
      if (v && a) m_push(32'h1000 + i*4);
    end
    trace_active = 1;
    reg_read(2'd2, d); chk("R9", d, m_w);
    reg_read(2'd1, d); chk("R11", d, 0);
    drain("R2");
    reg_read(2'd1, d); chk("R11", d, m_r);

    // R3: mark mode, other flags present but ignored
    reg_write(2'd0, 32'd2); m_ctrl(2);
    for (int i = 0; i < 10; i++) begin
      logic mk;
      mk = i[0] ^ i[2];
      es_step(1'b1, 1'b1, 32'h4000 + 32'(i), mk, 1'b1, 32'h1, 1'b1, 1'b1,
              32'h2, 1'b1, 32'h3, 32'h4);
      if (mk) m_push(32'h4000 + i);
    end
    drain("R3");

    // R8: every control value
    for (int m = 0; m < 32; m++) begin
      reg_write(2'd0, 32'hFFFF_FFE0 | 32'(m)); m_ctrl(m);
      reg_read(2'd0, d);
      chk("R8", d, 32'(m_mode) | (32'(m_err) << 8) | (32'(m_ovf) << 9));
    end

    // R4..R7: every subset of the two-entry modes against every event mix
    for (int md = 1; md < 8; md++) begin
      reg_write(2'd0, 32'(md << 2)); m_ctrl(md << 2);
      for (int ev = 0; ev < 16; ev++) begin
        logic [31:0] pc;
        int kinds;
        string tag;
        pc = 32'h2000_0000 + 32'(md*256 + ev*16);
        es_step(1'b1, 1'b1, pc, 1'b1, ev[0], pc ^ 32'h00F0_0000, ev[1], ev[3],
                pc ^ 32'h0A00_0000, ev[2], pc | 32'h4, 32'h100 + 32'(ev*8));
        kinds = 0;
        if (md[2] && ev[2]) kinds++;
        if (md[0] && ev[0]) kinds++;
        if (md[1] && ev[1]) kinds++;
        if (md[2] && ev[2]) begin
          m_push(pc | 32'h4); m_push(32'h100 + ev*8); tag = "R6";
        end else if (md[0] && ev[0]) begin
          m_push(pc); m_push(pc ^ 32'h00F0_0000); tag = "R4";
        end else begin
          tag = "R5";
          if (md[1] && ev[1]) begin
            m_push(pc);
            if (ev[3]) m_push(pc ^ 32'h0A00_0000);
          end
        end
        if (kinds > 1) tag = "R7";
        reg_read(2'd2, d); chk(tag, d, m_w);
        drain(tag);
      end
    end

    // R10: single-entry overflow
    reg_write(2'd0, 32'd1); m_ctrl(1);
    for (int i = 0; i < 20; i++) begin
      es_step(1'b1, 1'b1, 32'h3000 + 32'(i), 0, 0, 0, 0, 0, 0, 0, 0, 0);
      m_push(32'h3000 + i);
    end
    reg_read(2'd0, d); chk("R10", d, 32'h201);
    reg_read(2'd1, d); chk("R10", d, m_r);
    reg_read(2'd2, d); chk("R10", d, m_w);

    // R10: two-entry write into a full log
    reg_write(2'd0, 32'd4); m_ctrl(4);
    reg_read(2'd0, d); chk("R8", d, 32'h004);
    es_step(1'b1, 1'b1, 32'h5550, 0, 1'b1, 32'h6660, 0, 0, 0, 0, 0, 0);
    m_push(32'h5550); m_push(32'h6660);
    reg_read(2'd0, d); chk("R10", d, 32'h204);
    reg_read(2'd1, d); chk("R10", d, m_r);
    drain("R10");

    // R12: empty read
    reg_read(2'd1, r0);
    reg_read(2'd3, d); chk("R12", d, 0);
    reg_read(2'd1, d); chk("R12", d, r0);

    // R8: legal write clears overflow
    reg_write(2'd0, 32'd8); m_ctrl(8);
    reg_read(2'd0, d); chk("R8", d, 32'h008);

    @(negedge clk); clear_in();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule